// File: doc/BRIEF.md
# Interrupt Pin Generator

This block collects interrupt request flags and turns them into the level of an interrupt output pin. It has two flag banks. The first is a bank of core event flags, set by one-cycle event pulses from elsewhere in the chip. The second is a bank of eight general-purpose inputs. Each general-purpose input passes through a two-flop synchronizer, and an edge detector then sets its flag on the edge chosen by that input's polarity bit. Software clears a flag with a write-1-to-clear strobe. An enable bit per flag decides whether that flag may reach a pin.

The interrupt pin works in one of two styles. In level style it is an active-low open-drain output. In edge style it is a push-pull output that gives a pulse of programmable width for every new request. It also pulses again when a request is cleared while others are still pending. A second general-purpose output pin shows one of four internal status signals, chosen by a 2-bit selector. When routing is enabled, this second pin becomes another interrupt pin that carries only the general-purpose requests, with the same electrical behaviour as the main pin.

All pins are plain control signals, so no valid/ready handshake applies. Each flag bank reports its pending bits so that software can read them back.

Top module: `irq_pin_gen`

## Requirements
- R1: A general-purpose flag is set three clock edges after its input changes in the selected direction: polarity bit 1 selects a rising edge and 0 a falling edge. A change in the other direction leaves the flag clear.
- R2: A 1 on a bit of a clear strobe clears that pending bit at the next edge, and a 0 on a bit leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R3: A pending flag whose enable bit is 0 has no effect on either pin.
- R4: With the global enable at 0, the interrupt pin is inactive: released (oe=0) in level style, and driven at its inactive level (oe=1, o=~pos) in edge style.
- R5: In level style (irq_level=1) the pin drives low (o=0, oe=1) while any enabled flag is pending, and is released (oe=0) otherwise.
- R6: In edge style (irq_level=0) the pin is push-pull (oe=1). Its active level is 1 when irq_pos=1 and 0 when irq_pos=0. A pulse starts on the second clock edge after a new enabled request is flagged.
- R7: The pulse width is 1, 2, 4 or 8 times CLK_PER_US clock cycles for pw_sel codes 00, 01, 10 and 11.
- R8: In edge style, clearing a request while other enabled requests remain starts a new full pulse. If a pulse is already running when a new request or such a clear arrives, the pin goes inactive for exactly one cycle and then pulses for the full width. Clearing the last pending request gives no pulse.
- R9: The second pin is push-pull and shows op_ok for gpx_sel 00, vbus_det for 01, bus_act for 10 and sof_sq for 11.
- R10: With sep_irq=1 and gpx_sel=10, the second pin is an interrupt pin for the general-purpose flags only. It uses the same style, polarity, width and global enable as the main pin, and the general-purpose flags no longer drive the main pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gp_in | input | 8 | Asynchronous general-purpose inputs |
| gp_pol | input | 8 | Per-input active edge, 1 = rising |
| gp_en | input | 8 | Per-input interrupt enable |
| gp_clr | input | 8 | Write-1-to-clear strobe for the general-purpose flags |
| core_evt | input | NCORE | One-cycle set pulses for the core flags |
| core_en | input | NCORE | Core flag enables |
| core_clr | input | NCORE | Write-1-to-clear strobe for the core flags |
| irq_ie | input | 1 | Global interrupt enable |
| irq_level | input | 1 | 1 = level style, 0 = edge style |
| irq_pos | input | 1 | Edge-style active level, 1 = high |
| pw_sel | input | 2 | Pulse width code |
| sep_irq | input | 1 | Route general-purpose requests to the second pin |
| gpx_sel | input | 2 | Second-pin source select |
| op_ok | input | 1 | Chip operating status |
| vbus_det | input | 1 | Bus supply detected |
| bus_act | input | 1 | Bus activity |
| sof_sq | input | 1 | Frame-start square wave |
| int_o | output | 1 | Interrupt pin level |
| int_oe | output | 1 | Interrupt pin output enable |
| gpx_o | output | 1 | Second pin level |
| gpx_oe | output | 1 | Second pin output enable |
| gp_pend | output | 8 | General-purpose pending flags |
| core_pend | output | NCORE | Core pending flags |

## Verification
The assertions assume that core_evt and the clear strobes are synchronous to clk, and that only gp_in may change at any time. They also assume the inputs hold settled values while reset is asserted, so the state checks begin only once reset has been released. The stimulus changes every input just after the falling edge and keeps each strobe high for exactly one cycle. It holds gp_in steady long enough for the synchronizer to follow every change. The bench lowers CLK_PER_US to 4 so that every pulse width can be counted cycle by cycle.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  typedef enum logic [1:0] {
    GPX_OPERATE = 2'b00,
    GPX_VBUS    = 2'b01,
    GPX_BUSACT  = 2'b10,
    GPX_SOF     = 2'b11
  } gpx_sel_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'b00,
    PS_GAP   = 2'b01,
    PS_PULSE = 2'b10
  } pulse_st_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | set;
  end

  assign pend = pend_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((pend & $past(set)) == $past(set))); // R2

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0)); // R2
endmodule

// File: rtl/gpin_edge_detect.sv
module gpin_edge_detect #(
  parameter int N    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  output logic [N-1:0] hit
);
  logic [N-1:0] stg [SYNC];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < SYNC; i++) stg[i] <= stg[i-1];
      prev <= stg[SYNC-1];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit[i] = pol[i] ? (stg[SYNC-1][i] & ~prev[i]) : (~stg[SYNC-1][i] & prev[i]);
    end
  end
endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
  import irq_pin_pkg::*;
#(
  parameter int W          = 8,
  parameter int CLK_PER_US = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         ie,
  input  logic         level_mode,
  input  logic         pos,
  input  logic [1:0]   pw_sel,
  output logic         pin_o,
  output logic         pin_oe
);
  localparam int MAXLEN = CLK_PER_US * 8;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  logic [W-1:0]     eff, req_q;
  logic             new_req, drop, trig, pulse_on;
  logic [CNT_W-1:0] len, cnt;
  pulse_st_e        st;

  assign eff     = ie ? req : '0;
  assign new_req = |(eff & ~req_q);
  assign drop    = (|(req_q & ~eff)) & (|eff);
  assign trig    = new_req | drop;
  assign len     = CNT_W'(CLK_PER_US) << pw_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      st    <= PS_IDLE;
      cnt   <= '0;
    end else begin
      req_q <= eff;
      case (st)
        PS_IDLE: if (trig) begin
          st  <= PS_PULSE;
          cnt <= len - CNT_W'(1);
        end
        PS_GAP: begin
          st  <= PS_PULSE;
          cnt <= len - CNT_W'(1);
        end
        PS_PULSE: begin
          if (trig)            st  <= PS_GAP;
          else if (cnt == '0)  st  <= PS_IDLE;
          else                 cnt <= cnt - CNT_W'(1);
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign pulse_on = (st == PS_PULSE) & ie;

  always_comb begin
    if (level_mode) begin
      pin_o  = 1'b0;
      pin_oe = |eff;
    end else begin
      pin_oe = 1'b1;
      pin_o  = pos ? pulse_on : ~pulse_on;
    end
  end

  AST_GAP_THEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_GAP) |=> (st == PS_PULSE)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_IDLE && !trig) |=> (st == PS_IDLE)); // R6
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
  import irq_pin_pkg::*;
#(
  parameter int NCORE      = 4,
  parameter int NGP        = 8,
  parameter int SYNC       = 2,
  parameter int CLK_PER_US = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGP-1:0]   gp_in,
  input  logic [NGP-1:0]   gp_pol,
  input  logic [NGP-1:0]   gp_en,
  input  logic [NGP-1:0]   gp_clr,
  input  logic [NCORE-1:0] core_evt,
  input  logic [NCORE-1:0] core_en,
  input  logic [NCORE-1:0] core_clr,
  input  logic             irq_ie,
  input  logic             irq_level,
  input  logic             irq_pos,
  input  logic [1:0]       pw_sel,
  input  logic             sep_irq,
  input  logic [1:0]       gpx_sel,
  input  logic             op_ok,
  input  logic             vbus_det,
  input  logic             bus_act,
  input  logic             sof_sq,
  output logic             int_o,
  output logic             int_oe,
  output logic             gpx_o,
  output logic             gpx_oe,
  output logic [NGP-1:0]   gp_pend,
  output logic [NCORE-1:0] core_pend
);
  localparam int NINT = NCORE + NGP;

  logic [NGP-1:0]  gp_hit, gp_req;
  logic [NINT-1:0] int_req;
  logic            route_gp, sec_o, sec_oe;

  gpin_edge_detect #(.N(NGP), .SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .raw(gp_in), .pol(gp_pol), .hit(gp_hit)
  );

  irq_flag_bank #(.W(NGP)) u_gp_flags (
    .clk(clk), .rst_n(rst_n), .set(gp_hit), .clr(gp_clr), .pend(gp_pend)
  );

  irq_flag_bank #(.W(NCORE)) u_core_flags (
    .clk(clk), .rst_n(rst_n), .set(core_evt), .clr(core_clr), .pend(core_pend)
  );

  assign route_gp = sep_irq & (gpx_sel_e'(gpx_sel) == GPX_BUSACT);
  assign gp_req   = gp_pend & gp_en;
  assign int_req  = {core_pend & core_en, route_gp ? '0 : gp_req};

  irq_pin_driver #(.W(NINT), .CLK_PER_US(CLK_PER_US)) u_int_drv (
    .clk(clk), .rst_n(rst_n), .req(int_req), .ie(irq_ie),
    .level_mode(irq_level), .pos(irq_pos), .pw_sel(pw_sel),
    .pin_o(int_o), .pin_oe(int_oe)
  );

  irq_pin_driver #(.W(NGP), .CLK_PER_US(CLK_PER_US)) u_gpx_drv (
    .clk(clk), .rst_n(rst_n), .req(route_gp ? gp_req : '0), .ie(irq_ie),
    .level_mode(irq_level), .pos(irq_pos), .pw_sel(pw_sel),
    .pin_o(sec_o), .pin_oe(sec_oe)
  );

  always_comb begin
    gpx_oe = 1'b1;
    gpx_o  = 1'b0;
    unique case (gpx_sel_e'(gpx_sel))
      GPX_OPERATE: gpx_o = op_ok;
      GPX_VBUS:    gpx_o = vbus_det;
      GPX_BUSACT: begin
        if (route_gp) begin
          gpx_o  = sec_o;
          gpx_oe = sec_oe;
        end else begin
          gpx_o  = bus_act;
        end
      end
      GPX_SOF:     gpx_o = sof_sq;
      default:     gpx_o = 1'b0;
    endcase
  end

  AST_SEP_STRIPS_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (route_gp && irq_level && ((core_pend & core_en) == '0)) |-> !int_oe); // R10
endmodule

// File: tb/irq_pin_gen_tb_top.sv
`timescale 1ns/1ps
module irq_pin_gen_tb_top;
  localparam int NCORE = 4;
  localparam int CPU   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] gp_in = '0, gp_pol = '0, gp_en = '0, gp_clr = '0;
  logic [NCORE-1:0] core_evt = '0, core_en = '0, core_clr = '0;
  logic irq_ie = 1'b0, irq_level = 1'b1, irq_pos = 1'b1, sep_irq = 1'b0;
  logic [1:0] pw_sel = 2'b00, gpx_sel = 2'b00;
  logic op_ok = 1'b0, vbus_det = 1'b0, bus_act = 1'b0, sof_sq = 1'b0;
  logic int_o, int_oe, gpx_o, gpx_oe;
  logic [7:0] gp_pend;
  logic [NCORE-1:0] core_pend;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_pin_gen #(.NCORE(NCORE), .CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .gp_in(gp_in), .gp_pol(gp_pol), .gp_en(gp_en),
    .gp_clr(gp_clr), .core_evt(core_evt), .core_en(core_en), .core_clr(core_clr),
    .irq_ie(irq_ie), .irq_level(irq_level), .irq_pos(irq_pos), .pw_sel(pw_sel),
    .sep_irq(sep_irq), .gpx_sel(gpx_sel), .op_ok(op_ok), .vbus_det(vbus_det),
    .bus_act(bus_act), .sof_sq(sof_sq), .int_o(int_o), .int_oe(int_oe),
    .gpx_o(gpx_o), .gpx_oe(gpx_oe), .gp_pend(gp_pend), .core_pend(core_pend)
  );

  // {sel[1:0], op_ok, vbus_det, bus_act, sof_sq, expected gpx_o} for R9
  localparam logic [6:0] GPX_VEC [8] = '{
    7'b00_1000_1, 7'b00_0111_0, 7'b01_0100_1, 7'b01_1011_0,
    7'b10_0010_1, 7'b10_1101_0, 7'b11_0001_1, 7'b11_1110_0
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_len(input logic act_lvl, output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (int_o === act_lvl) n++;
      else if (n > 0) break;
    end
  endtask

  task automatic core_fire(input int b);
    core_evt[b] = 1'b1; tick(); core_evt = '0;
  endtask

  task automatic core_wipe(input int b);
    core_clr[b] = 1'b1; tick(); core_clr = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk("R5 reset int_oe", int_oe, 0);
    chk("R2 reset gp_pend", gp_pend, 0);
    chk("R2 reset core_pend", core_pend, 0);

    // R9 vector walk
    foreach (GPX_VEC[i]) begin
      {gpx_sel, op_ok, vbus_det, bus_act, sof_sq} = GPX_VEC[i][6:1];
      #1;
      chk("R9 gpx_o", gpx_o, GPX_VEC[i][0]);
      chk("R9 gpx_oe", gpx_oe, 1);
    end
    gpx_sel = 2'b00;

    // R1 edge selection through synchronizer
    irq_ie = 1'b1; irq_level = 1'b1; gp_en = 8'hFF; gp_pol = 8'h01;
    gp_in[0] = 1'b1;
    tick(); tick();
    chk("R1 not yet set", gp_pend[0], 0);
    tick();
    chk("R1 rising set", gp_pend[0], 1);
    chk("R5 level low", int_o, 0);
    chk("R5 level oe", int_oe, 1);
    gp_in[1] = 1'b1; repeat (4) tick();
    chk("R1 wrong edge ignored", gp_pend[1], 0);
    gp_in[1] = 1'b0; repeat (3) tick();
    chk("R1 falling set", gp_pend[1], 1);

    // R2 write-1-to-clear
    gp_clr = 8'h01; tick(); gp_clr = '0;
    chk("R2 clear bit0", gp_pend, 8'h02);
    gp_clr = 8'h00; tick();
    chk("R2 zero write no effect", gp_pend, 8'h02);
    gp_clr = 8'h02; tick(); gp_clr = '0;
    chk("R5 released", int_oe, 0);
    core_evt[0] = 1'b1; core_clr[0] = 1'b1; tick(); core_evt = '0; core_clr = '0;
    chk("R2 set beats clear", core_pend[0], 1);

    // R3 enable gating
    core_en = '0; tick();
    chk("R3 disabled flag quiet", int_oe, 0);
    core_en = 4'hF; tick();
    chk("R3 enabled flag drives", int_oe, 1);

    // R4 global enable
    irq_ie = 1'b0; tick();
    chk("R4 level ie off", int_oe, 0);
    irq_level = 1'b0; irq_pos = 1'b1; tick();
    chk("R4 edge ie off oe", int_oe, 1);
    chk("R4 edge ie off level", int_o, 0);
    core_wipe(0);
    irq_ie = 1'b1; repeat (3) tick();

    // R6/R7 edge pulses
    pw_sel = 2'b00;
    core_fire(1);
    chk("R6 pulse not before second edge", int_o, 0);
    tick();
    chk("R6 pulse active high", int_o, 1);
    chk("R6 push-pull", int_oe, 1);
    repeat (CPU + 2) tick();
    irq_pos = 1'b0; tick();
    chk("R6 idle level for pos=0", int_o, 1);
    for (int w = 0; w < 4; w++) begin
      pw_sel = 2'(w);
      core_wipe(1);
      repeat (3) tick();
      chk("R8 last clear no pulse", int_o, 1);
      core_fire(1);
      pulse_len(1'b0, n);
      chk("R7 pulse width", n, CPU << w);
    end
    core_wipe(1);
    repeat (3) tick();

    // R8 re-pulse on partial clear and retrigger
    irq_pos = 1'b1; pw_sel = 2'b00;
    core_fire(0); pulse_len(1'b1, n);
    core_fire(1); pulse_len(1'b1, n);
    repeat (2) tick();
    core_wipe(0);
    pulse_len(1'b1, n);
    chk("R8 clear with others pending pulses", n, CPU);
    repeat (2) tick();
    core_evt[2] = 1'b1; tick(); core_evt = '0;
    tick();
    chk("R8 pulse running", int_o, 1);
    tick();
    core_evt[3] = 1'b1; tick(); core_evt = '0;
    chk("R8 still active", int_o, 1);
    tick();
    chk("R8 one-cycle gap", int_o, 0);
    pulse_len(1'b1, n);
    chk("R8 full pulse after gap", n, CPU);
    core_wipe(1); core_wipe(2); core_wipe(3);
    repeat (3) tick();

    // R10 separate interrupt pin
    irq_level = 1'b1; sep_irq = 1'b1; gpx_sel = 2'b10; bus_act = 1'b1;
    gp_in[0] = 1'b0; repeat (4) tick();
    gp_in[0] = 1'b1; repeat (4) tick();
    chk("R10 gpx drives low", gpx_o, 0);
    chk("R10 gpx oe", gpx_oe, 1);
    chk("R10 int stripped", int_oe, 0);
    sep_irq = 1'b0; tick();
    chk("R10 gpx back to bus_act", gpx_o, 1);
    chk("R10 int carries gp", int_oe, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule